// File: doc/BRIEF.md
# Masked Event Trigger Unit

This unit produces the single start pulse that launches a vector sequence. It watches a 16-bit external event bus through a synchroniser and tests it against two programmable pattern/mask pairs, named D and T. A mask bit set to 1 removes that bit from its pair's comparison. The two pairs work in one of two modes. In concurrent mode, both pairs must match in the same clock. In sequential mode, a D match arms the unit and a later T match fires it.

The event-driven trigger is OR-combined with four other sources, and each source has its own enable. The other sources are a software command, an external trigger pin, one selectable line of an eight-line backplane trigger bus, and a star trigger input. For test-program checkout, a host-loaded emulation register can replace the live event bus as the comparator input.

The host reaches the unit through a simple synchronous register port: a write strobe, a 3-bit address, write data, and combinational read data. After each pulse the unit locks. It stays locked until the host issues a re-arm command. A status register reports which sources caused the last pulse, whether the D stage is armed, and whether the unit is locked.

Top module: `evt_trigger_unit`

## Requirements
- R1: After reset, trig_out is low, and every readable register reads 0, including status.
- R2: A pair matches when every event bit whose mask bit is 0 equals the corresponding pattern bit. Bits whose mask bit is 1 are ignored.
- R3: In concurrent mode (control bit 0 = 0), the event source is active only while D and T both match in the same cycle. A D match alone fires nothing.
- R4: In sequential mode (control bit 0 = 1), a D match arms the unit, and status bit 5 reads 1. A T match in a later cycle while armed fires the trigger. A T match without prior arming fires nothing.
- R5: The armed state holds through non-matching cycles until the trigger fires. A fire clears it, and so does a re-arm command (command bit 1).
- R6: With control bit 1 = 1, both comparators use the emulation register (address 5) and changes on the live event bus have no effect. With control bit 1 = 0, they use the live bus.
- R7: Live inputs pass through a two-stage synchroniser. A live event change made between clock edges produces the pulse after the third following rising edge, and not earlier.
- R8: Source enables sit in control bits 2 to 6: bit 2 software, bit 3 external pin, bit 4 backplane, bit 5 star, bit 6 event. A disabled source has no effect, and the enabled sources are ORed. Writing command bit 0 gives a software trigger, and its pulse follows the next rising edge.
- R9: Control bits 9:7 select which backplane line is the backplane source. The other lines are ignored.
- R10: trig_out is a one-cycle pulse on the rising edge of the combined condition. After a pulse, no further pulse occurs until a re-arm command.
- R11: Status (address 7) is laid out as follows. Bits 4:0 hold the sources that were active at the last fire, in enable order: bit 0 software up to bit 4 event. Bit 5 is the armed flag and bit 6 is the locked flag.
- R12: Register map:
  - 0: control
  - 1: D pattern
  - 2: D mask
  - 3: T pattern
  - 4: T mask
  - 5: emulation
  - 6: command (write-only)
  - 7: status

  Written values read back from addresses 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| ev_bus | input | 16 | Asynchronous external event bus |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| bp_trig_in | input | 8 | Asynchronous backplane trigger lines |
| star_trig_in | input | 1 | Asynchronous star trigger input |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
Assertions check the following on every cycle:
- A pulse never lasts two cycles.
- No pulse appears between a pulse and the next re-arm.
- The armed flag is clear whenever a pulse is out, and stays clear while concurrent mode was selected.
- Every recorded cause is a source that was enabled.

The bench scenarios are needed for the rest:
- the mask comparison over random patterns;
- the order dependence of sequential mode;
- emulation masking the live bus;
- the three-edge synchroniser latency;
- backplane line selection.

// File: rtl/evtrg_pkg.sv
// evtrg_pkg: shared constants and types for the masked event trigger unit.
// Assumes an 8-line backplane trigger bus and a 3-bit register address.
package evtrg_pkg;
    localparam int NSRC     = 5;
    localparam int BP_LINES = 8;
    localparam int BP_SEL_W = $clog2(BP_LINES);
    localparam int ADDR_W   = 3;

    // source bit positions in enables and cause
    localparam int S_SW   = 0;
    localparam int S_EXT  = 1;
    localparam int S_BP   = 2;
    localparam int S_STAR = 3;
    localparam int S_EVT  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DPAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_DMSK = 3'd2;
    localparam logic [ADDR_W-1:0] A_TPAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_TMSK = 3'd4;
    localparam logic [ADDR_W-1:0] A_EMU  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

    // control word: bit0 sequential, bit1 emulation, [6:2] enables, [9:7] line select
    typedef struct packed {
        logic [BP_SEL_W-1:0] bp_sel;
        logic [NSRC-1:0]     src_en;
        logic                emu_sel;
        logic                seq_mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evtrg_sync.sv
// evtrg_sync: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2; bits are synchronised independently (no coherency).
module evtrg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // shift the input through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/evtrg_match.sv
// evtrg_match: one mask-qualified pattern comparator.
// A set mask bit excludes that bit; purely combinational.
module evtrg_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] bus,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] msk,
    output logic         hit
);
    // hit when no unmasked bit differs from the pattern
    always_comb hit = ~|((bus ^ pat) & ~msk);
endmodule

// File: rtl/evtrg_regs.sv
// evtrg_regs: host register file, command decode and read mux.
// Assumes EV_W >= CTRL_W; command writes produce single-cycle strobes.
module evtrg_regs
    import evtrg_pkg::*;
#(
    parameter int EV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EV_W-1:0]   wdata,
    output ctrl_t             ctrl,
    output logic [EV_W-1:0]   d_pat,
    output logic [EV_W-1:0]   d_msk,
    output logic [EV_W-1:0]   t_pat,
    output logic [EV_W-1:0]   t_msk,
    output logic [EV_W-1:0]   emu_val,
    output logic              sw_trig,
    output logic              rearm,
    input  logic [NSRC-1:0]   cause,
    input  logic              armed,
    input  logic              locked,
    output logic [EV_W-1:0]   rdata
);
    logic cmd_wr;

    // register writes from the host port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            d_pat   <= '0;
            d_msk   <= '0;
            t_pat   <= '0;
            t_msk   <= '0;
            emu_val <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:  ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_DPAT:  d_pat   <= wdata;
                A_DMSK:  d_msk   <= wdata;
                A_TPAT:  t_pat   <= wdata;
                A_TMSK:  t_msk   <= wdata;
                A_EMU:   emu_val <= wdata;
                default: ;
            endcase
        end
    end

    // command strobes decoded straight from the write cycle
    always_comb begin
        cmd_wr  = wr_en && (addr == A_CMD);
        sw_trig = cmd_wr && wdata[0];
        rearm   = cmd_wr && wdata[1];
    end

    // read multiplexer
    always_comb begin
        case (addr)
            A_CTRL:  rdata = EV_W'(ctrl);
            A_DPAT:  rdata = d_pat;
            A_DMSK:  rdata = d_msk;
            A_TPAT:  rdata = t_pat;
            A_TMSK:  rdata = t_msk;
            A_EMU:   rdata = emu_val;
            A_STAT:  rdata = EV_W'({locked, armed, cause});
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/evtrg_seq.sv
// evtrg_seq: sequencing, source combining, edge detection and lockout.
// Assumes all source inputs are already synchronous to clk.
module evtrg_seq
    import evtrg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seq_mode,
    input  logic            d_hit,
    input  logic            t_hit,
    input  logic [NSRC-1:0] src_en,
    input  logic            sw_trig,
    input  logic            ext_trig,
    input  logic            bp_line,
    input  logic            star_trig,
    input  logic            rearm,
    output logic            trig_out,
    output logic [NSRC-1:0] cause,
    output logic            armed,
    output logic            locked
);
    logic            evt_cond;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] active;
    logic            combined;
    logic            comb_q;
    logic            fire;

    // event condition, enabled sources and the rising-edge fire decision
    always_comb begin
        evt_cond     = seq_mode ? (armed & t_hit) : (d_hit & t_hit);
        raw          = '0;
        raw[S_SW]    = sw_trig;
        raw[S_EXT]   = ext_trig;
        raw[S_BP]    = bp_line;
        raw[S_STAR]  = star_trig;
        raw[S_EVT]   = evt_cond;
        active       = raw & src_en;
        combined     = |active;
        fire         = combined & ~comb_q & ~locked;
    end

    // D-stage arming for sequential mode
    always_ff @(posedge clk) begin
        if (!rst_n)                            armed <= 1'b0;
        else if (fire || rearm || !seq_mode)   armed <= 1'b0;
        else if (d_hit && !locked)             armed <= 1'b1;
    end

    // lockout: set by a fire, released by re-arm
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b0;
        else if (fire)   locked <= 1'b1;
        else if (rearm)  locked <= 1'b0;
    end

    // output pulse, edge history and cause capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_out <= 1'b0;
            comb_q   <= 1'b0;
            cause    <= '0;
        end else begin
            trig_out <= fire;
            comb_q   <= combined;
            if (fire) cause <= active;
        end
    end
endmodule

// File: rtl/evt_trigger_unit.sv
// evt_trigger_unit: masked event trigger unit top level.
// Assumes asynchronous trigger inputs and a host port synchronous to clk.
module evt_trigger_unit
    import evtrg_pkg::*;
#(
    parameter int EV_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [EV_W-1:0]     wdata,
    output logic [EV_W-1:0]     rdata,
    input  logic [EV_W-1:0]     ev_bus,
    input  logic                ext_trig_in,
    input  logic [BP_LINES-1:0] bp_trig_in,
    input  logic                star_trig_in,
    output logic                trig_out
);
    localparam int PIN_W = BP_LINES + 2;

    ctrl_t               ctrl;
    logic [EV_W-1:0]     d_pat, d_msk, t_pat, t_msk, emu_val;
    logic [EV_W-1:0]     ev_live, ev_src;
    logic [PIN_W-1:0]    pins_s;
    logic                sw_trig, rearm_w;
    logic                d_hit, t_hit, bp_line;
    logic [NSRC-1:0]     cause_w;
    logic                armed_w, locked_w;
    logic                seq_mode_w;
    logic [NSRC-1:0]     src_en_w;

    evtrg_regs #(.EV_W(EV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl(ctrl), .d_pat(d_pat), .d_msk(d_msk), .t_pat(t_pat), .t_msk(t_msk),
        .emu_val(emu_val), .sw_trig(sw_trig), .rearm(rearm_w),
        .cause(cause_w), .armed(armed_w), .locked(locked_w), .rdata(rdata)
    );

    evtrg_sync #(.W(EV_W), .STAGES(SYNC_STAGES)) u_sync_ev (
        .clk(clk), .rst_n(rst_n), .d(ev_bus), .q(ev_live)
    );

    evtrg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync_pins (
        .clk(clk), .rst_n(rst_n), .d({star_trig_in, ext_trig_in, bp_trig_in}), .q(pins_s)
    );

    // comparator input: emulation register or live synchronised bus
    always_comb begin
        ev_src     = ctrl.emu_sel ? emu_val : ev_live;
        bp_line    = pins_s[ctrl.bp_sel];
        seq_mode_w = ctrl.seq_mode;
        src_en_w   = ctrl.src_en;
    end

    evtrg_match #(.W(EV_W)) u_match_d (.bus(ev_src), .pat(d_pat), .msk(d_msk), .hit(d_hit));
    evtrg_match #(.W(EV_W)) u_match_t (.bus(ev_src), .pat(t_pat), .msk(t_msk), .hit(t_hit));

    evtrg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode_w), .d_hit(d_hit), .t_hit(t_hit),
        .src_en(src_en_w), .sw_trig(sw_trig), .ext_trig(pins_s[BP_LINES]),
        .bp_line(bp_line), .star_trig(pins_s[BP_LINES+1]), .rearm(rearm_w),
        .trig_out(trig_out), .cause(cause_w), .armed(armed_w), .locked(locked_w)
    );
endmodule

// File: rtl/evtrg_chk.sv
// evtrg_chk: assertion checker bound to evt_trigger_unit.
// Assumes visibility of the top's internal armed, cause, enable and re-arm nets.
module evtrg_chk
    import evtrg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            trig_out,
    input logic            armed,
    input logic            seq_mode,
    input logic            rearm,
    input logic [NSRC-1:0] cause,
    input logic [NSRC-1:0] src_en
);
    logic fired_flag;

    // remembers a pulse until the next re-arm command
    always_ff @(posedge clk) begin
        if (!rst_n)        fired_flag <= 1'b0;
        else if (rearm)    fired_flag <= 1'b0;
        else if (trig_out) fired_flag <= 1'b1;
    end

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired_flag |-> !trig_out);

    // R5
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> !armed);

    // R3
    conc_noarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(seq_mode) |-> !armed);

    // R11
    cause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ((cause != '0) && ((cause & ~$past(src_en)) == '0)));
endmodule

bind evt_trigger_unit evtrg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .armed(armed_w),
    .seq_mode(seq_mode_w), .rearm(rearm_w), .cause(cause_w), .src_en(src_en_w)
);

// File: tb/test_evt_trigger_unit.sv
module test_evt_trigger_unit;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] ev_bus = '0;
    logic        ext_trig_in = 1'b0;
    logic [7:0]  bp_trig_in = '0;
    logic        star_trig_in = 1'b0;
    logic        trig_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    evt_trigger_unit i_evt_trigger_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_bus(ev_bus), .ext_trig_in(ext_trig_in),
        .bp_trig_in(bp_trig_in), .star_trig_in(star_trig_in), .trig_out(trig_out)
    );

    function automatic logic [15:0] mk_ctrl(bit seq, bit emu, logic [4:0] en, logic [2:0] sel);
        return {6'd0, sel, en, emu, seq};
    endfunction

    function automatic bit pair_hit(logic [15:0] b, logic [15:0] p, logic [15:0] m);
        return (((b ^ p) & ~m) == 16'h0);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic count_pulses(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trig_out) cnt++;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int cnt;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 trig", trig_out, 0);
        for (int a = 0; a < 8; a++) begin
            if (a == 6) continue;
            rd(a[2:0], r);
            chk("R1 reg", r, 0);
        end

        // R12 readback
        for (int a = 0; a < 6; a++) begin
            logic [15:0] v = (a == 0) ? 16'h0202 : 16'($urandom);
            wr(a[2:0], v);
            rd(a[2:0], r);
            chk("R12 readback", r, v);
        end
        wr(0, 16'h0);
        wr(6, 16'h2);

        // R8 software trigger, R10 single pulse and lockout
        wr(0, mk_ctrl(0, 0, 5'b00001, 0));
        wr(6, 16'h1);
        chk("R8 sw pulse", trig_out, 1);
        @(negedge clk);
        chk("R10 one cycle", trig_out, 0);
        rd(7, r);
        chk("R11 status sw", r, 16'h41);
        wr(6, 16'h1);
        chk("R10 locked sw", trig_out, 0);
        count_pulses(3, cnt);
        chk("R10 locked none", cnt, 0);
        wr(6, 16'h2);
        wr(6, 16'h1);
        chk("R10 rearm sw", trig_out, 1);

        // R8 external pin disabled then enabled
        wr(0, mk_ctrl(0, 0, 5'b00001, 0));
        wr(6, 16'h2);
        @(negedge clk); ext_trig_in = 1'b1;
        count_pulses(5, cnt);
        chk("R8 ext disabled", cnt, 0);
        ext_trig_in = 1'b0;
        wr(0, mk_ctrl(0, 0, 5'b00010, 0));
        wr(6, 16'h2);
        @(negedge clk); ext_trig_in = 1'b1;
        count_pulses(5, cnt);
        chk("R8 ext enabled", cnt, 1);
        rd(7, r);
        chk("R11 status ext", r, 16'h42);
        ext_trig_in = 1'b0;

        // R8 star input
        wr(0, mk_ctrl(0, 0, 5'b01000, 0));
        wr(6, 16'h2);
        @(negedge clk); star_trig_in = 1'b1;
        count_pulses(5, cnt);
        chk("R8 star", cnt, 1);
        rd(7, r);
        chk("R11 status star", r, 16'h48);
        star_trig_in = 1'b0;

        // R9 backplane line select
        wr(0, mk_ctrl(0, 0, 5'b00100, 3'd5));
        wr(6, 16'h2);
        @(negedge clk); bp_trig_in = 8'h04;
        count_pulses(5, cnt);
        chk("R9 other line", cnt, 0);
        bp_trig_in = 8'h20;
        count_pulses(5, cnt);
        chk("R9 selected line", cnt, 1);
        rd(7, r);
        chk("R11 status bp", r, 16'h44);
        bp_trig_in = 8'h00;

        // R7 live bus latency
        wr(0, mk_ctrl(0, 0, 5'b10000, 0));
        wr(1, 16'h1234); wr(2, 16'h0); wr(3, 16'h1234); wr(4, 16'h0);
        wr(6, 16'h2);
        @(negedge clk); ev_bus = 16'h1234;
        @(negedge clk); chk("R7 edge1", trig_out, 0);
        @(negedge clk); chk("R7 edge2", trig_out, 0);
        @(negedge clk); chk("R7 edge3", trig_out, 1);

        // R6 emulation hides live bus, then fires from register
        wr(5, 16'h0);
        wr(0, mk_ctrl(0, 1, 5'b10000, 0));
        wr(6, 16'h2);
        @(negedge clk); ev_bus = 16'h0;
        @(negedge clk); ev_bus = 16'h1234;
        count_pulses(5, cnt);
        chk("R6 live ignored", cnt, 0);
        wr(5, 16'h1234);
        count_pulses(3, cnt);
        chk("R6 emu fires", cnt, 1);

        // R3 concurrent: D alone fires nothing; T fully masked completes it
        wr(0, mk_ctrl(0, 1, 5'b00000, 0));
        wr(5, 16'h0);
        wr(6, 16'h2);
        wr(1, 16'h00A5); wr(2, 16'h0); wr(3, 16'h5A00); wr(4, 16'h0);
        wr(0, mk_ctrl(0, 1, 5'b10000, 0));
        wr(5, 16'h00A5);
        count_pulses(4, cnt);
        chk("R3 D only", cnt, 0);
        rd(7, r);
        chk("R3 no arm", r[5], 0);
        wr(4, 16'hFFFF);
        count_pulses(3, cnt);
        chk("R2 R3 T masked", cnt, 1);

        // R4 R5 sequential
        wr(4, 16'h0);
        wr(5, 16'h0);
        wr(0, mk_ctrl(1, 1, 5'b10000, 0));
        wr(6, 16'h2);
        wr(5, 16'h5A00);
        count_pulses(4, cnt);
        chk("R4 T without arm", cnt, 0);
        wr(5, 16'h00A5);
        @(negedge clk);
        rd(7, r);
        chk("R4 armed", r[5], 1);
        wr(5, 16'h0);
        count_pulses(4, cnt);
        chk("R5 hold no pulse", cnt, 0);
        rd(7, r);
        chk("R5 still armed", r[5], 1);
        wr(5, 16'h5A00);
        count_pulses(3, cnt);
        chk("R4 D then T", cnt, 1);
        rd(7, r);
        chk("R5 R11 status after fire", r, 16'h50);
        wr(5, 16'h0);
        wr(6, 16'h2);
        wr(5, 16'h00A5);
        wr(5, 16'h0);
        wr(6, 16'h2);
        rd(7, r);
        chk("R5 rearm clears", r[5], 0);
        wr(5, 16'h5A00);
        count_pulses(4, cnt);
        chk("R5 no fire after clear", cnt, 0);

        // R2 random concurrent mask comparisons
        for (int k = 0; k < 200; k++) begin
            logic [15:0] dp, dm, tp, tm, e;
            bit exp;
            dp = 16'($urandom);
            dm = 16'($urandom & $urandom);
            e  = dp ^ 16'($urandom & $urandom & $urandom);
            tp = e ^ 16'($urandom & $urandom & $urandom);
            tm = 16'($urandom & $urandom);
            exp = pair_hit(e, dp, dm) && pair_hit(e, tp, tm);
            wr(0, mk_ctrl(0, 1, 5'b00000, 0));
            wr(6, 16'h2);
            wr(1, dp); wr(2, dm); wr(3, tp); wr(4, tm); wr(5, e);
            wr(0, mk_ctrl(0, 1, 5'b10000, 0));
            count_pulses(3, cnt);
            chk("R2 random match", cnt, {31'd0, exp});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule